// File: doc/BRIEF.md
# Multi-Channel Virtual-Address Burst DMA

This block moves bulk data between main memory and a local scratchpad on behalf of a near-memory processor. Software loads a channel with a virtual main-memory address, a scratchpad address, a byte count and a direction, and the channel runs until the whole range has moved. Ranges may start at any byte and have any length. Several channels can run at once, and each one can have more than one burst waiting for a response.

Each channel cuts its range into bursts. The first burst ends at the next boundary of the maximum burst size. Every later burst starts on such a boundary. The last burst carries whatever bytes remain. A single shared engine serves the channels in turn: it sends the virtual address of the burst to an external translation port, and then issues one memory request with the physical address, the scratchpad address, the byte count and the byte enables of the first and last bus word. A channel reports done once every burst has been issued and every response has returned. If a translation faults, the channel stops and reports an error.

Top module: `vdma_engine`

## Requirements
- R1: After reset, every channel shows busy, done and error low, and neither the translation port nor the request port is valid.
- R2: A start pulse to a channel that is not busy loads that channel, raises busy, and clears done and error. A start pulse to a busy channel has no effect on the requests that channel makes.
- R3: The first burst holds min(remaining, MAXB − va mod MAXB) bytes. Each later burst starts at a multiple of MAXB. No burst is empty, exceeds MAXB bytes or crosses a MAXB boundary, and the byte counts add up to the programmed length.
- R4: Before each burst is issued, its virtual address is presented on the translation port. The request address is the physical address that the port returns. Because the page size is a multiple of MAXB, a burst never spans two pages. The translation address stays steady until the port acknowledges it.
- R5: req_be_first_o has bit k set for every k ≥ (addr mod BB). req_be_last_o has bit k set for every k ≤ ((addr + bytes − 1) mod BB). BB is the bus width in bytes.
- R6: Direction 0 issues memory reads into the scratchpad (req_write_o = 0). Direction 1 issues memory writes from the scratchpad (req_write_o = 1). The scratchpad address starts at the programmed value and advances by each burst's byte count.
- R7: When several channels have bursts pending, grants rotate in round-robin order, and each grant issues one burst.
- R8: A request holds its fields until req_ready_i accepts it. A channel may have several bursts outstanding. Done rises only after the response to the last burst, and done and busy are never high together.
- R9: A translation fault sets that channel's error bit. The channel issues no further requests, done stays low, and busy drops once its outstanding responses have drained. Other channels carry on unaffected. Error and done are never high together.
- R10: A zero-length start issues no request and reaches done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the channel named by start_ch_i |
| start_ch_i | input | CW | Channel being programmed |
| start_dir_i | input | 1 | 0: memory to scratchpad, 1: scratchpad to memory |
| start_va_i | input | AW | Virtual main-memory start address |
| start_spm_i | input | AW | Scratchpad start address |
| start_len_i | input | LW | Transfer length in bytes |
| busy_o | output | NCH | Channel running |
| done_o | output | NCH | Channel finished successfully (sticky until next start) |
| err_o | output | NCH | Channel stopped on a translation fault |
| xl_valid_o | output | 1 | Translation request valid |
| xl_va_o | output | AW | Virtual address to translate |
| xl_ack_i | input | 1 | Translation result valid |
| xl_pa_i | input | AW | Physical address returned |
| xl_fault_i | input | 1 | Translation fault |
| req_valid_o | output | 1 | Memory burst request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_write_o | output | 1 | 1: write memory, 0: read memory |
| req_ch_o | output | CW | Issuing channel, echoed in the response |
| req_addr_o | output | AW | Physical memory address |
| req_spm_o | output | AW | Scratchpad address |
| req_bytes_o | output | MB+1 | Burst length in bytes |
| req_be_first_o | output | BB | Byte enables of the first bus word |
| req_be_last_o | output | BB | Byte enables of the last bus word |
| rsp_valid_i | input | 1 | Burst response valid |
| rsp_ch_i | input | CW | Channel the response belongs to |

## Verification
The bench runs several kinds of transfer. An unaligned range that spans several boundaries checks the shortened first burst, the full middle bursts and the short last burst. An aligned write-direction range separates the two directions and the scratchpad stepping. A three-byte range inside one bus word shows whether the first and last byte enables are formed independently. Two channels started together expose whether grants rotate. Withholding responses tells "done after issue" apart from "done after the last response", and also shows that a restart of a busy channel is ignored. A range that walks into a faulting page, run next to a healthy channel, separates a stopped channel from a stalled engine.

// File: rtl/vdma_engine.sv
module vdma_engine #(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int MAXB = 256,
  parameter int BB   = 8,
  parameter int OW   = 4,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MB  = $clog2(MAXB),
  localparam int BW  = $clog2(BB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CW-1:0]    start_ch_i,
  input  logic             start_dir_i,
  input  logic [AW-1:0]    start_va_i,
  input  logic [AW-1:0]    start_spm_i,
  input  logic [LW-1:0]    start_len_i,
  output logic [NCH-1:0]   busy_o,
  output logic [NCH-1:0]   done_o,
  output logic [NCH-1:0]   err_o,
  output logic             xl_valid_o,
  output logic [AW-1:0]    xl_va_o,
  input  logic             xl_ack_i,
  input  logic [AW-1:0]    xl_pa_i,
  input  logic             xl_fault_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic             req_write_o,
  output logic [CW-1:0]    req_ch_o,
  output logic [AW-1:0]    req_addr_o,
  output logic [AW-1:0]    req_spm_o,
  output logic [MB:0]      req_bytes_o,
  output logic [BB-1:0]    req_be_first_o,
  output logic [BB-1:0]    req_be_last_o,
  input  logic             rsp_valid_i,
  input  logic [CW-1:0]    rsp_ch_i
);

  typedef enum logic [1:0] {S_IDLE, S_XL, S_ISS} st_t;
  st_t st;

  logic [AW-1:0]  va_q  [NCH];
  logic [AW-1:0]  spm_q [NCH];
  logic [LW-1:0]  rem_q [NCH];
  logic [OW-1:0]  out_q [NCH];
  logic [NCH-1:0] dir_q, busy_q, done_q, err_q;
  logic [NCH-1:0] pend, inc_v, dec_v;
  logic [CW-1:0]  sel_q, ptr_q, pick;
  logic           any;
  logic [AW-1:0]  pa_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pend[c]  = busy_q[c] && !err_q[c] && (rem_q[c] != '0) && (out_q[c] != '1);
    assign inc_v[c] = (st == S_ISS) && req_ready_i && (sel_q == CW'(c));
    assign dec_v[c] = rsp_valid_i && (rsp_ch_i == CW'(c));
  end

  always_comb begin
    int idx;
    pick = ptr_q;
    any  = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(ptr_q) + k) % NCH;
      if (!any && pend[idx]) begin
        pick = CW'(idx);
        any  = 1'b1;
      end
    end
  end

  logic [MB-1:0] off;
  logic [LW-1:0] room, blen;
  logic [BW-1:0] lo, hi;
  assign off  = va_q[sel_q][MB-1:0];
  assign room = LW'(MAXB) - LW'(off);
  assign blen = (rem_q[sel_q] < room) ? rem_q[sel_q] : room;
  assign lo   = pa_q[BW-1:0];
  assign hi   = lo + blen[BW-1:0] - BW'(1);

  assign xl_valid_o     = (st == S_XL);
  assign xl_va_o        = va_q[sel_q];
  assign req_valid_o    = (st == S_ISS);
  assign req_write_o    = dir_q[sel_q];
  assign req_ch_o       = sel_q;
  assign req_addr_o     = pa_q;
  assign req_spm_o      = spm_q[sel_q];
  assign req_bytes_o    = blen[MB:0];
  assign req_be_first_o = {BB{1'b1}} << lo;
  assign req_be_last_o  = {BB{1'b1}} >> (BW'(BB - 1) - hi);
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sel_q  <= '0;
      ptr_q  <= CW'(NCH - 1);
      pa_q   <= '0;
      dir_q  <= '0;
      busy_q <= '0;
      done_q <= '0;
      err_q  <= '0;
      for (int c = 0; c < NCH; c++) begin
        va_q[c]  <= '0;
        spm_q[c] <= '0;
        rem_q[c] <= '0;
        out_q[c] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (any) begin
          sel_q <= pick;
          st    <= S_XL;
        end
        S_XL: if (xl_ack_i) begin
          if (xl_fault_i) begin
            err_q[sel_q] <= 1'b1;
            ptr_q        <= sel_q;
            st           <= S_IDLE;
          end else begin
            pa_q <= xl_pa_i;
            st   <= S_ISS;
          end
        end
        S_ISS: if (req_ready_i) begin
          va_q[sel_q]  <= va_q[sel_q] + AW'(blen);
          spm_q[sel_q] <= spm_q[sel_q] + AW'(blen);
          rem_q[sel_q] <= rem_q[sel_q] - blen;
          ptr_q        <= sel_q;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      for (int c = 0; c < NCH; c++) begin
        out_q[c] <= out_q[c] + OW'(inc_v[c]) - OW'(dec_v[c]);
        if (start_i && start_ch_i == CW'(c) && !busy_q[c]) begin
          va_q[c]   <= start_va_i;
          spm_q[c]  <= start_spm_i;
          rem_q[c]  <= start_len_i;
          dir_q[c]  <= start_dir_i;
          busy_q[c] <= 1'b1;
          done_q[c] <= 1'b0;
          err_q[c]  <= 1'b0;
        end else if (busy_q[c] && out_q[c] == '0 && (rem_q[c] == '0 || err_q[c]) &&
                     !(st != S_IDLE && sel_q == CW'(c))) begin
          busy_q[c] <= 1'b0;
          done_q[c] <= !err_q[c];
        end
      end
    end
  end

endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int MAXB = 256,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MB  = $clog2(MAXB)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] err,
  input logic           xl_valid,
  input logic           xl_ack,
  input logic [AW-1:0]  xl_va,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  req_addr,
  input logic [MB:0]    req_bytes,
  input logic [CW-1:0]  req_ch,
  input logic           rsp_valid,
  input logic [CW-1:0]  rsp_ch
);

  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != '0) && (({1'b0, req_addr[MB-1:0]} + req_bytes) <= (MB+1)'(MAXB)));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_bytes) && $stable(req_ch));

  assert_xl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && !xl_ack |=> xl_valid && $stable(xl_va));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done & busy) == '0);

  assert_err_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done & err) == '0);

  assert_rsp_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy[rsp_ch]);

endmodule

bind vdma_engine vdma_engine_chk #(.NCH(NCH), .AW(AW), .MAXB(MAXB)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .err(err_o),
  .xl_valid(xl_valid_o), .xl_ack(xl_ack_i), .xl_va(xl_va_o),
  .req_valid(req_valid_o), .req_ready(req_ready_i), .req_addr(req_addr_o),
  .req_bytes(req_bytes_o), .req_ch(req_ch_o),
  .rsp_valid(rsp_valid_i), .rsp_ch(rsp_ch_i)
);

// File: tb/vdma_engine_tb_top.sv
`timescale 1ns/1ps
module vdma_engine_tb_top;
  localparam logic [31:0] OFS = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        start_i = 0, start_ch_i = 0, start_dir_i = 0;
  logic [31:0] start_va_i = 0, start_spm_i = 0;
  logic [15:0] start_len_i = 0;
  logic [1:0]  busy_o, done_o, err_o;
  logic        xl_valid_o, xl_ack_i, xl_fault_i;
  logic [31:0] xl_va_o, xl_pa_i;
  logic        req_valid_o, req_ready_i = 1, req_write_o;
  logic        req_ch_o;
  logic [31:0] req_addr_o, req_spm_o;
  logic [8:0]  req_bytes_o;
  logic [7:0]  req_be_first_o, req_be_last_o;
  logic        rsp_valid_i = 0, rsp_ch_i = 0;

  assign xl_ack_i   = xl_valid_o;
  assign xl_pa_i    = xl_va_o + OFS;
  assign xl_fault_i = (xl_va_o[31:28] == 4'hF);

  vdma_engine dut_i (.*);

  int n_chk = 0, n_err = 0, cyc = 0;
  bit hold = 0, fin = 0;

  logic        lg_ch [64];
  logic [31:0] lg_addr [64], lg_spm [64];
  logic [8:0]  lg_bytes [64];
  logic        lg_wr [64];
  logic [7:0]  lg_bf [64], lg_bl [64];
  int lg_n = 0;
  logic fq [64];
  int fw = 0, fr = 0;

  always @(posedge clk) if (rst_n && req_valid_o && req_ready_i) begin
    lg_ch[lg_n % 64] <= req_ch_o;  lg_addr[lg_n % 64] <= req_addr_o;
    lg_spm[lg_n % 64] <= req_spm_o; lg_bytes[lg_n % 64] <= req_bytes_o;
    lg_wr[lg_n % 64] <= req_write_o; lg_bf[lg_n % 64] <= req_be_first_o;
    lg_bl[lg_n % 64] <= req_be_last_o;
    lg_n <= lg_n + 1;
    fq[fw % 64] <= req_ch_o;
    fw <= fw + 1;
  end

  always @(negedge clk) begin
    cyc++;
    req_ready_i = (cyc % 3 != 0);
    if (!hold && fr != fw && (cyc % 2 == 0)) begin
      rsp_valid_i = 1; rsp_ch_i = fq[fr % 64]; fr++;
    end else rsp_valid_i = 0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic prog(input logic ch, input logic dir, input logic [31:0] va, spm, input logic [15:0] len);
    @(negedge clk);
    start_i = 1; start_ch_i = ch; start_dir_i = dir;
    start_va_i = va; start_spm_i = spm; start_len_i = len;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_free(input logic ch);
    for (int i = 0; i < 5000 && busy_o[ch]; i++) @(negedge clk);
  endtask

  task automatic verify(input int base, input logic ch, input logic dir,
                        input logic [31:0] va, spm, input int len, input int n_exp);
    logic [31:0] v = va, s = spm;
    int r = len, cnt = 0, e, endb;
    for (int i = base; i < lg_n; i++) if (lg_ch[i % 64] == ch) begin
      e = (r < 256 - int'(v % 256)) ? r : 256 - int'(v % 256);
      endb = int'((v + e - 1) % 8);
      chk(lg_addr[i % 64] == v + OFS, "R4 translated addr", lg_addr[i % 64], v + OFS);
      chk(lg_bytes[i % 64] == 9'(e), "R3 burst bytes", lg_bytes[i % 64], e);
      chk(lg_spm[i % 64] == s, "R6 spm addr", lg_spm[i % 64], s);
      chk(lg_wr[i % 64] == dir, "R6 direction", lg_wr[i % 64], dir);
      chk(lg_bf[i % 64] == (8'hFF << (v % 8)), "R5 first be", lg_bf[i % 64], 8'hFF << (v % 8));
      chk(lg_bl[i % 64] == (8'hFF >> (7 - endb)), "R5 last be", lg_bl[i % 64], 8'hFF >> (7 - endb));
      v += e; s += e; r -= e; cnt++;
    end
    chk(r == 0, "R3 total bytes", len - r, len);
    chk(cnt == n_exp, "R3 burst count", cnt, n_exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 status", {busy_o, done_o, err_o}, 0);
    chk(!req_valid_o && !xl_valid_o, "R1 ports idle", {req_valid_o, xl_valid_o}, 0);
  endtask

  task automatic t_single(input logic ch, input logic dir, input logic [31:0] va, spm,
                          input int len, input int n_exp);
    int base = lg_n;
    prog(ch, dir, va, spm, 16'(len));
    wait_free(ch);
    repeat (2) @(negedge clk);
    chk(done_o[ch] && !err_o[ch], "R8 done", done_o[ch], 1);
    verify(base, ch, dir, va, spm, len, n_exp);
  endtask

  task automatic t_zero;
    int base = lg_n;
    prog(1, 0, 32'h500, 32'h10, 0);
    wait_free(1);
    @(negedge clk);
    chk(done_o[1] == 1, "R10 zero length done", done_o[1], 1);
    chk(lg_n == base, "R10 no request", lg_n - base, 0);
  endtask

  task automatic t_hold_ignore;
    int base = lg_n;
    hold = 1;
    prog(0, 1, 32'h3000, 32'h40, 16'h100);
    repeat (20) @(negedge clk);
    chk(done_o[0] == 0 && busy_o[0] == 1, "R8 done waits for response", {done_o[0], busy_o[0]}, 1);
    prog(0, 0, 32'h9000, 32'h0, 16'h8);
    hold = 0;
    wait_free(0);
    @(negedge clk);
    chk(done_o[0] == 1, "R8 done after response", done_o[0], 1);
    verify(base, 0, 1, 32'h3000, 32'h40, 32'h100, 1);
    chk(lg_addr[base % 64] == 32'h3000 + OFS, "R2 restart ignored", lg_addr[base % 64], 32'h3000 + OFS);
  endtask

  task automatic t_rr;
    int base = lg_n;
    prog(0, 0, 32'h6000, 32'h0, 16'h400);
    prog(1, 0, 32'h7000, 32'h800, 16'h400);
    wait_free(0); wait_free(1);
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk(lg_ch[(base + i) % 64] == 1'(i % 2), "R7 round robin", lg_ch[(base + i) % 64], i % 2);
    verify(base, 1, 0, 32'h7000, 32'h800, 32'h400, 4);
  endtask

  task automatic t_fault;
    int base = lg_n, c0 = 0;
    prog(0, 0, 32'hEFFF_FF00, 32'h0, 16'h300);
    prog(1, 1, 32'h8010, 32'h100, 16'h200);
    wait_free(0); wait_free(1);
    repeat (2) @(negedge clk);
    for (int i = base; i < lg_n; i++) if (lg_ch[i % 64] == 0) c0++;
    chk(c0 == 1, "R9 faulted channel stops", c0, 1);
    chk(err_o[0] && !done_o[0] && !busy_o[0], "R9 error status", {err_o[0], done_o[0], busy_o[0]}, 3'b100);
    chk(done_o[1] && !err_o[1], "R9 other channel completes", {done_o[1], err_o[1]}, 2'b10);
    verify(base, 1, 1, 32'h8010, 32'h100, 32'h200, 3);
    prog(0, 0, 32'h0, 32'h0, 0);
    wait_free(0);
    @(negedge clk);
    chk(!err_o[0] && done_o[0], "R2 start clears error", {err_o[0], done_o[0]}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single(0, 0, 32'h1F3, 32'h20, 32'h220, 4);
    t_single(1, 1, 32'h4000, 32'h200, 32'h300, 3);
    t_single(0, 0, 32'h2002, 32'h7, 3, 1);
    t_zero();
    t_hold_ignore();
    t_rr();
    t_fault();
    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule